// File: doc/BRIEF.md
# I2C Master Command-Queue Sequencer

This block is an I2C bus master that is driven entirely by a queue of command words. Each word names one byte slot on the bus: a byte to send, or a slot in which a byte is read. Each word also carries its own flags, so that word alone says whether a repeated START comes first and whether a STOP follows. A complete combined write-then-read transaction can therefore be queued up front, with no further control writes. Bytes read from the target are placed in a receive queue. Fill levels of both queues, a status vector and an abort-cause vector can be read back.

The sequencer drives open-drain SCL and SDA: an output-enable of 1 pulls the line low, and a released line reads high. The low time and the high time of SCL are each set by a cycle count on the `scl_half` input. The target address is a 7-bit value taken from a port. The R/W bit sent with the address is taken from the first command word after a START or repeated START. If the queue runs dry before a STOP has been requested, the sequencer holds SCL low and waits for more words. Any abort (missing ACK, general-call read, lost arbitration) ends the transfer with STOP and empties the transmit queue. The block then stays idle until the cause vector is cleared.

Top module: `i2cq_master`

## Requirements
- R1: A command word has the data byte in bits 7:0, a read-slot flag in bit 8, a STOP-after flag in bit 9 and a RESTART-before flag in bit 10. A push into a full transmit queue (64 entries) is dropped, and the level stays at 64.
- R2: `tx_level` and `rx_level` report the queue fill counts. `status` holds activity in bit 0, tx-not-full in bit 1, tx-empty in bit 2, rx-not-empty in bit 3, rx-full in bit 4, master-busy in bit 5 and slave-busy in bit 6 (always 0). After reset, status is 7'b0000110 and both levels are 0.
- R3: A write word with the STOP flag set produces START, the address with R/W=0, the data byte, a sampled ACK and then STOP.
- R4: In a read slot, SDA is released for all eight data bits, whatever the data bits of the word hold, and the byte sampled from the bus enters the receive queue. The master ACKs the byte unless the STOP flag is set. With the STOP flag it NACKs and then issues STOP.
- R5: A word with the RESTART flag, when it is not the first word after an address, causes a repeated START and a new address byte. The R/W bit of that address is 1 if the word is a read slot.
- R6: If the transmit queue is empty and no STOP has been requested, SCL is held low and the master stays busy. It resumes when a word arrives.
- R7: A NACK on the address byte sets cause bit 0. Every abort issues STOP, flushes the transmit queue and returns to idle.
- R8: A NACK on a written data byte sets cause bit 3.
- R9: A read slot with target address 0 (general call) sets cause bit 5 and flushes the transmit queue. No START is placed on the bus.
- R10: When the master releases SDA to send a 1 during an address or data bit but samples 0, cause bit 12 (lost arbitration) is set.
- R11: While the cause vector is non-zero, no new transfer starts. A one-cycle `abort_clr` pulse clears the vector.
- R12: `en_stat` follows `en_req` only while the master is idle, one cycle later. A new transfer starts only when `en_stat` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_req | input | 1 | Requested enable |
| en_stat | output | 1 | Actual enable state |
| tgt_addr | input | 7 | 7-bit target address |
| scl_half | input | TW (16) | Cycles per SCL low phase and per SCL high phase |
| cmd_push | input | 1 | Push `cmd_word` into the transmit queue |
| cmd_word | input | 11 | Command word |
| rx_pop | input | 1 | Remove the head of the receive queue |
| rx_data | output | 8 | Head of the receive queue |
| tx_level | output | LW (7) | Transmit queue fill count |
| rx_level | output | LW (7) | Receive queue fill count |
| status | output | 7 | Status vector |
| abort_cause | output | 16 | Abort cause vector |
| abort_clr | input | 1 | Clear the abort cause vector |
| scl_in | input | 1 | Sensed SCL line |
| sda_in | input | 1 | Sensed SDA line |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
Queue levels change one clock edge after a push or pop. A pushed word reaches the bus as START two edges after the push. `en_stat` follows `en_req` one edge after the master is seen idle. Bus results and abort causes are final once master-busy drops. The bench therefore samples levels on the falling edge after the push edge, and waits for master-busy to clear plus one more cycle before comparing received bytes, cause bits or `en_stat`. A bus-level target model inside the bench records START and STOP counts, written bytes, address direction and the master's last ACK bit. These records let the bench check bus events that the ports alone do not show.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;
    localparam int CMD_W   = 11;
    localparam int CAUSE_W = 16;

    // abort cause bit positions
    localparam int CZ_ADDR_NACK = 0;
    localparam int CZ_DATA_NACK = 3;
    localparam int CZ_GC_READ   = 5;
    localparam int CZ_ARB_LOST  = 12;

    typedef enum logic [2:0] {
        S_IDLE, S_START, S_RSTART, S_BIT, S_CMD, S_STOP
    } seq_st_e;

    // word layout: restart(10) stop(9) read(8) data(7:0)
    typedef struct packed {
        logic       restart;
        logic       stop;
        logic       rd;
        logic [7:0] data;
    } cmd_t;
endpackage

// File: rtl/i2cq_fifo.sv
module i2cq_fifo #(
    parameter int W     = 11,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    input  logic          flush,
    output logic [W-1:0]  dout,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [LW-1:0] lvl;
    } fq_t;

    fq_t q, d;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign full    = (q.lvl == LW'(DEPTH));
    assign empty   = (q.lvl == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[q.rd];
    assign level   = q.lvl;

    always_comb begin
        d = q;
        if (flush) begin
            d = '0;
        end else begin
            if (do_push) d.wr = (q.wr == AW'(DEPTH - 1)) ? '0 : q.wr + 1'b1;
            if (do_pop)  d.rd = (q.rd == AW'(DEPTH - 1)) ? '0 : q.rd + 1'b1;
            d.lvl = q.lvl + LW'(do_push) - LW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[q.wr] <= din;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (level == $past(level))); // R1
    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (level <= LW'(DEPTH))); // R2
endmodule

// File: rtl/i2cq_seq.sv
module i2cq_seq
    import i2cq_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_req,
    input  logic [6:0]         tgt_addr,
    input  logic [TW-1:0]      scl_half,
    input  logic [CMD_W-1:0]   head,
    input  logic               tx_empty,
    input  logic               rx_full,
    input  logic               abort_clr,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               tx_pop,
    output logic               tx_flush,
    output logic               rx_push,
    output logic [7:0]         rx_byte,
    output logic               scl_oe,
    output logic               sda_oe,
    output logic               busy,
    output logic [CAUSE_W-1:0] cause,
    output logic               en_stat
);
    typedef struct packed {
        seq_st_e            st;
        logic [1:0]         ph;
        logic [3:0]         bitn;
        logic [TW-1:0]      cnt;
        logic [7:0]         sh;
        logic               xmit;
        logic               isaddr;
        logic               fresh;
        logic               last;
        logic [CAUSE_W-1:0] cause;
        logic               en;
    } seq_t;

    seq_t q, d;
    cmd_t hc;
    logic [TW-1:0] reload;
    logic drive1, scl_drv, stretch, tick, gc_rd;

    function automatic seq_t go_stop(seq_t s, logic [TW-1:0] rl);
        s.st  = S_STOP;
        s.ph  = 2'd0;
        s.cnt = rl;
        return s;
    endfunction

    assign hc     = cmd_t'(head);
    assign reload = (scl_half == '0) ? '0 : scl_half - 1'b1;
    assign gc_rd  = (tgt_addr == 7'd0) && hc.rd;

    // line drive from registered state
    always_comb begin
        drive1 = 1'b1;
        if (q.bitn < 4'd8) drive1 = q.xmit ? q.sh[7] : 1'b1;
        else               drive1 = q.xmit ? 1'b1 : q.last;
        scl_drv = 1'b0;
        sda_oe  = 1'b0;
        unique case (q.st)
            S_IDLE:   begin scl_drv = 1'b0;          sda_oe = 1'b0;          end
            S_START:  begin scl_drv = 1'b0;          sda_oe = 1'b1;          end
            S_RSTART: begin scl_drv = (q.ph == 2'd0); sda_oe = (q.ph == 2'd2); end
            S_BIT:    begin scl_drv = (q.ph == 2'd0); sda_oe = !drive1;       end
            S_CMD:    begin scl_drv = 1'b1;          sda_oe = 1'b0;          end
            S_STOP:   begin scl_drv = (q.ph == 2'd0); sda_oe = (q.ph != 2'd2); end
            default:  begin scl_drv = 1'b0;          sda_oe = 1'b0;          end
        endcase
    end

    assign scl_oe  = scl_drv;
    assign stretch = (q.st != S_IDLE) && (q.st != S_CMD) && !scl_drv && !scl_in;
    assign tick    = (q.cnt == '0) && !stretch;

    always_comb begin
        d        = q;
        tx_pop   = 1'b0;
        tx_flush = 1'b0;
        rx_push  = 1'b0;
        if (abort_clr) d.cause = '0;
        if (tick)          d.cnt = reload;
        else if (!stretch) d.cnt = q.cnt - 1'b1;

        unique case (q.st)
            S_IDLE: begin
                d.cnt = reload;
                d.en  = en_req;
                if (q.en && !tx_empty && (q.cause == '0)) begin
                    if (gc_rd) begin
                        d.cause[CZ_GC_READ] = 1'b1;
                        tx_flush = 1'b1;
                    end else begin
                        d.st     = S_START;
                        d.sh     = {tgt_addr, hc.rd};
                        d.xmit   = 1'b1;
                        d.isaddr = 1'b1;
                        d.bitn   = '0;
                    end
                end
            end
            S_START: begin
                if (tick) begin
                    d.st   = S_BIT;
                    d.ph   = 2'd0;
                    d.bitn = '0;
                end
            end
            S_RSTART: begin
                if (tick) begin
                    if (q.ph == 2'd2) begin
                        d.st   = S_BIT;
                        d.ph   = 2'd0;
                        d.bitn = '0;
                    end else begin
                        d.ph = q.ph + 2'd1;
                    end
                end
            end
            S_BIT: begin
                if (tick) begin
                    if (q.ph == 2'd0) begin
                        d.ph = 2'd1;
                    end else if (q.bitn < 4'd8) begin
                        if (q.xmit && q.sh[7] && !sda_in) begin
                            d = go_stop(d, reload);
                            d.cause[CZ_ARB_LOST] = 1'b1;
                            tx_flush = 1'b1;
                        end else begin
                            d.sh   = {q.sh[6:0], sda_in};
                            d.bitn = q.bitn + 4'd1;
                            d.ph   = 2'd0;
                        end
                    end else if (q.xmit && sda_in) begin
                        d = go_stop(d, reload);
                        if (q.isaddr) d.cause[CZ_ADDR_NACK] = 1'b1;
                        else          d.cause[CZ_DATA_NACK] = 1'b1;
                        tx_flush = 1'b1;
                    end else begin
                        rx_push = !q.xmit;
                        if (!q.isaddr && q.last) begin
                            d = go_stop(d, reload);
                        end else begin
                            d.st    = S_CMD;
                            d.fresh = q.isaddr;
                        end
                    end
                end
            end
            S_CMD: begin
                d.cnt = reload;
                if (!tx_empty) begin
                    if (hc.restart && !q.fresh) begin
                        if (gc_rd) begin
                            d = go_stop(d, reload);
                            d.cause[CZ_GC_READ] = 1'b1;
                            tx_flush = 1'b1;
                        end else begin
                            d.st     = S_RSTART;
                            d.ph     = 2'd0;
                            d.sh     = {tgt_addr, hc.rd};
                            d.xmit   = 1'b1;
                            d.isaddr = 1'b1;
                        end
                    end else if (!(hc.rd && rx_full)) begin
                        tx_pop   = 1'b1;
                        d.st     = S_BIT;
                        d.ph     = 2'd0;
                        d.bitn   = '0;
                        d.isaddr = 1'b0;
                        d.fresh  = 1'b0;
                        d.last   = hc.stop;
                        d.xmit   = !hc.rd;
                        d.sh     = hc.rd ? 8'hFF : hc.data;
                    end
                end
            end
            S_STOP: begin
                if (tick) begin
                    if (q.ph == 2'd2) d.st = S_IDLE;
                    else              d.ph = q.ph + 2'd1;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_byte = q.sh;
    assign busy    = (q.st != S_IDLE);
    assign cause   = q.cause;
    assign en_stat = q.en;

    AST_ABORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_IDLE && q.cause != '0) |=> (q.st == S_IDLE)); // R11
    AST_EN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != S_IDLE) |=> (q.en == $past(q.en))); // R12
    AST_DRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_CMD && tx_empty) |=> (q.st == S_CMD && scl_oe)); // R6
    AST_NACK_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && q.last) |=> (q.st == S_STOP)); // R4
endmodule

// File: rtl/i2cq_master.sv
module i2cq_master
    import i2cq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int TW    = 16,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_req,
    output logic               en_stat,
    input  logic [6:0]         tgt_addr,
    input  logic [TW-1:0]      scl_half,
    input  logic               cmd_push,
    input  logic [CMD_W-1:0]   cmd_word,
    input  logic               rx_pop,
    output logic [7:0]         rx_data,
    output logic [LW-1:0]      tx_level,
    output logic [LW-1:0]      rx_level,
    output logic [6:0]         status,
    output logic [CAUSE_W-1:0] abort_cause,
    input  logic               abort_clr,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               scl_oe,
    output logic               sda_oe
);
    logic [CMD_W-1:0] tx_head;
    logic tx_full, tx_empty, rx_full, rx_empty;
    logic tx_pop, tx_flush, rx_push, busy;
    logic [7:0] rx_byte;

    i2cq_fifo #(.W(CMD_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(cmd_push), .din(cmd_word),
        .pop(tx_pop), .flush(tx_flush), .dout(tx_head), .level(tx_level),
        .full(tx_full), .empty(tx_empty)
    );

    i2cq_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_byte),
        .pop(rx_pop), .flush(1'b0), .dout(rx_data), .level(rx_level),
        .full(rx_full), .empty(rx_empty)
    );

    i2cq_seq #(.TW(TW)) u_seq (
        .clk(clk), .rst_n(rst_n), .en_req(en_req), .tgt_addr(tgt_addr),
        .scl_half(scl_half), .head(tx_head), .tx_empty(tx_empty),
        .rx_full(rx_full), .abort_clr(abort_clr), .scl_in(scl_in),
        .sda_in(sda_in), .tx_pop(tx_pop), .tx_flush(tx_flush),
        .rx_push(rx_push), .rx_byte(rx_byte), .scl_oe(scl_oe),
        .sda_oe(sda_oe), .busy(busy), .cause(abort_cause), .en_stat(en_stat)
    );

    assign status = {1'b0, busy, rx_full, !rx_empty, tx_empty, !tx_full, busy};

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_flush && !cmd_push) |=> (tx_level == '0)); // R7
endmodule

// File: tb/tb_i2cq_master.sv
module tb_i2cq_master;
    localparam logic [6:0] SLV = 7'h2A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_req = 1'b0, en_stat;
    logic [6:0] tgt_addr = SLV;
    logic [15:0] scl_half = 16'd4;
    logic cmd_push = 1'b0;
    logic [10:0] cmd_word = '0;
    logic rx_pop = 1'b0;
    logic [7:0] rx_data;
    logic [6:0] tx_level, rx_level, status;
    logic [15:0] abort_cause;
    logic abort_clr = 1'b0;
    logic scl_oe, sda_oe;
    logic slv_low = 1'b0, force_low = 1'b0;
    logic scl_line, sda_line;

    assign scl_line = !scl_oe;
    assign sda_line = !(sda_oe || slv_low || force_low);

    always #4 clk = !clk;

    i2cq_master dut (
        .clk(clk), .rst_n(rst_n), .en_req(en_req), .en_stat(en_stat),
        .tgt_addr(tgt_addr), .scl_half(scl_half), .cmd_push(cmd_push),
        .cmd_word(cmd_word), .rx_pop(rx_pop), .rx_data(rx_data),
        .tx_level(tx_level), .rx_level(rx_level), .status(status),
        .abort_cause(abort_cause), .abort_clr(abort_clr),
        .scl_in(scl_line), .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    // bus-level target model
    logic sp = 1'b1, sdp = 1'b1, act = 1'b0, addrph = 1'b0, rd = 1'b0;
    logic match = 1'b0, mack = 1'b0, ack_wr = 1'b1;
    logic [7:0] sh = '0;
    logic [7:0] wr_log [16];
    logic [7:0] rd_q [16];
    int bitn = 0, starts = 0, stops = 0, wr_n = 0, rd_idx = 0;

    always @(negedge clk) begin
        logic sc, sd;
        sc = scl_line;
        sd = sda_line;
        if (sp && sc && sdp && !sd) begin
            starts++; act = 1'b1; bitn = -1; addrph = 1'b1; slv_low = 1'b0;
        end else if (sp && sc && !sdp && sd) begin
            stops++; act = 1'b0; slv_low = 1'b0;
        end else if (act) begin
            if (!sp && sc) begin
                if (bitn >= 0 && bitn < 8) begin
                    if (addrph || !rd) sh = {sh[6:0], sd};
                end else if (bitn == 8 && rd && !addrph) mack = sd;
            end else if (sp && !sc) begin
                bitn++;
                if (bitn == 8) begin
                    if (addrph) begin
                        match = (sh[7:1] == SLV); rd = sh[0]; slv_low = match;
                    end else if (!rd) begin
                        wr_log[wr_n % 16] = sh; wr_n++; slv_low = ack_wr;
                    end else slv_low = 1'b0;
                end else if (bitn == 9) begin
                    bitn = 0;
                    if (addrph) begin
                        addrph = 1'b0;
                        if (!match) begin act = 1'b0; slv_low = 1'b0; end
                        else if (rd) slv_low = !rd_q[rd_idx % 16][7];
                        else slv_low = 1'b0;
                    end else if (rd) begin
                        rd_idx++;
                        if (mack) begin act = 1'b0; slv_low = 1'b0; end
                        else slv_low = !rd_q[rd_idx % 16][7];
                    end else slv_low = 1'b0;
                end else if (rd && !addrph && bitn > 0) begin
                    slv_low = !rd_q[rd_idx % 16][7 - bitn];
                end
            end
        end
        sp = sc;
        sdp = sd;
    end

    int n_chk = 0, n_err = 0;

    task automatic chk(input string req, input logic [31:0] a, input logic [31:0] e);
        n_chk++;
        if (a !== e) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, a, e);
        end
    endtask

    task automatic push(input logic [10:0] w);
        @(negedge clk); cmd_push = 1'b1; cmd_word = w;
        @(negedge clk); cmd_push = 1'b0;
    endtask

    task automatic pop_rx();
        @(negedge clk); rx_pop = 1'b1;
        @(negedge clk); rx_pop = 1'b0;
    endtask

    task automatic clr_abort();
        @(negedge clk); abort_clr = 1'b1;
        @(negedge clk); abort_clr = 1'b0;
    endtask

    task automatic run_idle();
        repeat (3) @(negedge clk);
        while (status[5]) @(negedge clk);
        @(negedge clk);
    endtask

    // {read, value}: write rows send value, read rows expect value from target
    localparam logic [8:0] VEC [6] = '{
        {1'b0, 8'hA5}, {1'b1, 8'h3C}, {1'b0, 8'h00},
        {1'b1, 8'hFF}, {1'b0, 8'hFF}, {1'b1, 8'h81}
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog (R1..R12 run) actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int s0, p0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        chk("R2 reset status", 32'(status), 32'h06);
        chk("R2 reset levels", {tx_level, rx_level}, '0);
        chk("R2 reset lines", {30'd0, scl_oe, sda_oe}, 32'd0);
        chk("R12 reset en_stat", 32'(en_stat), 32'd0);
        en_req = 1'b1;
        @(negedge clk);
        chk("R12 en_stat follows", 32'(en_stat), 32'd1);

        foreach (VEC[i]) begin
            s0 = stops;
            if (!VEC[i][8]) begin
                push({3'b010, VEC[i][7:0]});
                run_idle();
                chk("R3 written byte", 32'(wr_log[(wr_n - 1) % 16]), 32'(VEC[i][7:0]));
                chk("R3 rw bit 0", 32'(rd), 32'd0);
                chk("R3 stop issued", 32'(stops - s0), 32'd1);
            end else begin
                rd_q[rd_idx % 16] = VEC[i][7:0];
                push({3'b011, 8'h00});
                run_idle();
                chk("R4 read byte", 32'(rx_data), 32'(VEC[i][7:0]));
                chk("R4 final nack", 32'(mack), 32'd1);
                chk("R4 stop after read", 32'(stops - s0), 32'd1);
                pop_rx();
            end
        end

        // R5 combined write then restart read of two bytes
        s0 = starts;
        rd_q[rd_idx % 16] = 8'h5A;
        rd_q[(rd_idx + 1) % 16] = 8'hC3;
        push({3'b000, 8'h11});
        push({3'b101, 8'h00});
        push({3'b011, 8'h00});
        run_idle();
        chk("R5 two starts", 32'(starts - s0), 32'd2);
        chk("R5 write before restart", 32'(wr_log[(wr_n - 1) % 16]), 32'h11);
        chk("R5 rw after restart", 32'(rd), 32'd1);
        chk("R2 rx level two", 32'(rx_level), 32'd2);
        chk("R5 first read byte", 32'(rx_data), 32'h5A);
        pop_rx();
        chk("R2 rx level after pop", 32'(rx_level), 32'd1);
        chk("R5 second read byte", 32'(rx_data), 32'hC3);
        pop_rx();

        // R6 queue runs dry without stop
        push({3'b000, 8'h77});
        repeat (400) @(negedge clk);
        chk("R6 busy while dry", 32'(status[5]), 32'd1);
        chk("R6 scl held low", 32'(scl_oe), 32'd1);
        push({3'b010, 8'h78});
        run_idle();
        chk("R6 resumed bytes", {wr_log[(wr_n - 2) % 16], wr_log[(wr_n - 1) % 16]}, 32'h7778);

        // R12 disable while busy
        push({3'b010, 8'h42});
        repeat (20) @(negedge clk);
        en_req = 1'b0;
        @(negedge clk);
        chk("R12 en_stat held busy", 32'(en_stat), 32'd1);
        run_idle();
        chk("R12 en_stat drops idle", 32'(en_stat), 32'd0);

        // R1 queue full, push ignored
        for (int k = 0; k < 65; k++) push({3'b010, 8'(k)});
        chk("R1 level capped", 32'(tx_level), 32'd64);
        chk("R2 tx not-full clear", 32'(status[2:1]), 32'd0);

        // R7 address nack aborts
        s0 = stops;
        tgt_addr = 7'h33;
        en_req = 1'b1;
        run_idle();
        chk("R7 cause addr nack", 32'(abort_cause), 32'h0001);
        chk("R7 queue flushed", 32'(tx_level), 32'd0);
        chk("R7 stop on abort", 32'(stops - s0), 32'd1);

        // R11 held while cause set
        tgt_addr = SLV;
        s0 = starts;
        push({3'b010, 8'h55});
        repeat (100) @(negedge clk);
        chk("R11 held idle", {24'd0, tx_level, status[5]}, 32'h02);
        chk("R11 no start", 32'(starts - s0), 32'd0);
        clr_abort();
        run_idle();
        chk("R11 cleared", 32'(abort_cause), 32'd0);
        chk("R11 runs after clear", 32'(wr_log[(wr_n - 1) % 16]), 32'h55);

        // R8 data nack
        ack_wr = 1'b0;
        push({3'b010, 8'h99});
        run_idle();
        chk("R8 cause data nack", 32'(abort_cause), 32'h0008);
        ack_wr = 1'b1;
        clr_abort();

        // R9 general-call read
        tgt_addr = 7'd0;
        s0 = starts;
        push({3'b011, 8'h00});
        repeat (10) @(negedge clk);
        chk("R9 cause gc read", 32'(abort_cause), 32'h0020);
        chk("R9 no start", 32'(starts - s0), 32'd0);
        chk("R9 flushed", 32'(tx_level), 32'd0);
        clr_abort();
        tgt_addr = SLV;

        // R10 lost arbitration (line forced low)
        @(negedge clk); force_low = 1'b1;
        p0 = rx_level;
        push({3'b010, 8'hF0});
        run_idle();
        chk("R10 cause arb lost", 32'(abort_cause), 32'h1000);
        chk("R10 no rx push", 32'(rx_level), 32'(p0));
        @(negedge clk); force_low = 1'b0;
        clr_abort();

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule